// File: doc/BRIEF.md
# Predicated SIMD Integer Multiplier

This block multiplies two packed integer vectors lane by lane and returns a packed vector of the same width. An element-type select divides the vector into 16-bit or 32-bit lanes. A per-lane predicate mask picks which lanes carry a product. Every lane whose predicate is clear comes out as zero. The old destination contents are never kept. Each lane holds only the low half of its product, at the lane width, so overflow wraps.

The unit is fully pipelined and has no stall path. It accepts a request in any cycle, and a valid flag travels with the data. The result appears a fixed number of cycles later, and that number is the same for both lane widths. A request that carries an element type the unit does not support still takes its pipeline slot. In that slot it comes out with an error flag raised and an all-zero data vector.

Top module: `simd_mul_unit`

## Requirements
- R1: When `in_etype` is 2'b01 (16-bit lanes), result bits [16i+15:16i] equal the low 16 bits of `in_a[16i+15:16i]` times `in_b[16i+15:16i]` for every lane i whose `in_mask[i]` is 1.
- R2: When `in_etype` is 2'b10 (32-bit lanes), result bits [32k+31:32k] equal the low 32 bits of the product of the 32-bit source lanes k. Lane k is gated by `in_mask[2k]` alone, and `in_mask[2k+1]` has no effect on the result.
- R3: Every lane whose predicate bit is 0 produces zero. Data from earlier results is never merged into it.
- R4: Product bits above the lane width are discarded. For example, 16'hFFFF times 16'hFFFF gives 16'h0001, so signed and unsigned operands give the same result.
- R5: `out_valid` rises exactly LATENCY (default 8) clock cycles after a cycle in which `in_valid` is high, for either lane width. It is low otherwise.
- R6: An `in_etype` of 2'b00 (8-bit lanes) or 2'b11 (reserved) is illegal. For such a request, `out_valid` and `out_bad_type` are both high in the request's output slot, and `out_data` is all zero.
- R7: A new request is accepted in every cycle, so back-to-back requests of mixed types each produce their own result in consecutive cycles.
- R8: In any cycle where `out_valid` is low, `out_data` is zero and `out_bad_type` is low. Inputs presented while `in_valid` is low have no effect on the outputs.
- R9: While `rst_n` is low and right after it is released, `out_valid` and `out_bad_type` are low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_etype | input | 2 | Element type: 00 8-bit (illegal), 01 16-bit, 10 32-bit, 11 reserved (illegal) |
| in_mask | input | VEC_W/16 | Predicate, one bit per 16-bit lane |
| in_a | input | VEC_W | First source vector |
| in_b | input | VEC_W | Second source vector |
| out_valid | output | 1 | Result present this cycle |
| out_bad_type | output | 1 | Result slot belongs to an illegal-type request |
| out_data | output | VEC_W | Packed lane-wise product |

## Verification
The bench builds the block with its default parameters: a 256-bit vector, a 16-bit mask and a latency of 8. With these values there are 16 lanes in 16-bit mode and 8 lanes in 32-bit mode, and up to eight requests are in flight at once. This lets the bench drive a full-rate stream of mixed legal and illegal types. It also checks the all-ones wrap case and mask patterns where only the odd mask bits are set in 32-bit mode. Idle cycles carry random data, to show that the unused inputs have no effect.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
   typedef enum logic [1:0] {
      ET_B8  = 2'b00,
      ET_H16 = 2'b01,
      ET_W32 = 2'b10,
      ET_RSV = 2'b11
   } etype_e;
endpackage

// File: rtl/vmul_pipe.sv
module vmul_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_reg
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[DEPTH-1];
   end
endmodule

// File: rtl/vmul_lanes.sv
module vmul_lanes
   import vmul_pkg::*;
#(
   parameter int VEC_W = 256,
   localparam int NWORD  = VEC_W / 32,
   localparam int MASK_W = VEC_W / 16
) (
   input  logic [1:0]        etype,
   input  logic [MASK_W-1:0] mask,
   input  logic [VEC_W-1:0]  a,
   input  logic [VEC_W-1:0]  b,
   output logic [VEC_W-1:0]  prod,
   output logic              bad
);
   assign bad = (etype == ET_B8) || (etype == ET_RSV);

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      logic [31:0] aw, bw, p32, pw;
      logic [15:0] pl, ph;
      assign aw  = a[32*w +: 32];
      assign bw  = b[32*w +: 32];
      assign pl  = aw[15:0] * bw[15:0];
      assign ph  = aw[31:16] * bw[31:16];
      assign p32 = aw * bw;
      always_comb begin
         case (etype)
            ET_H16:  pw = {mask[2*w+1] ? ph : 16'h0, mask[2*w] ? pl : 16'h0};
            ET_W32:  pw = mask[2*w] ? p32 : 32'h0;
            default: pw = '0;
         endcase
      end
      assign prod[32*w +: 32] = pw;
   end
endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit #(
   parameter int VEC_W   = 256,
   parameter int LATENCY = 8,
   localparam int MASK_W = VEC_W / 16,
   localparam int PIPE_W = VEC_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_etype,
   input  logic [MASK_W-1:0] in_mask,
   input  logic [VEC_W-1:0]  in_a,
   input  logic [VEC_W-1:0]  in_b,
   output logic              out_valid,
   output logic              out_bad_type,
   output logic [VEC_W-1:0]  out_data
);
   if (VEC_W < 32 || VEC_W % 32 != 0) begin : g_chk_w
      $error("simd_mul_unit: VEC_W must be a positive multiple of 32");
   end
   if (LATENCY < 2) begin : g_chk_lat
      $error("simd_mul_unit: LATENCY must be at least 2");
   end

   logic [VEC_W-1:0]  raw_prod;
   logic              raw_bad;
   logic [VEC_W-1:0]  s0_data;
   logic              s0_bad;
   logic [PIPE_W-1:0] pipe_q;

   vmul_lanes #(.VEC_W(VEC_W)) u_lanes (
      .etype (in_etype),
      .mask  (in_mask),
      .a     (in_a),
      .b     (in_b),
      .prod  (raw_prod),
      .bad   (raw_bad)
   );

   assign s0_bad  = in_valid && raw_bad;
   assign s0_data = (in_valid && !raw_bad) ? raw_prod : '0;

   vmul_pipe #(.W(PIPE_W), .DEPTH(LATENCY)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({in_valid, s0_bad, s0_data}),
      .q     (pipe_q)
   );

   assign out_valid    = pipe_q[PIPE_W-1];
   assign out_bad_type = pipe_q[PIPE_W-2];
   assign out_data     = pipe_q[VEC_W-1:0];
endmodule

// File: rtl/vmul_sva.sv
module vmul_sva #(
   parameter int VEC_W   = 256,
   parameter int LATENCY = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_etype,
   input logic             out_valid,
   input logic             out_bad_type,
   input logic [VEC_W-1:0] out_data
);
   logic [LATENCY-1:0] hist_v, hist_b;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_v <= '0;
         hist_b <= '0;
      end else begin
         hist_v <= {hist_v[LATENCY-2:0], in_valid};
         hist_b <= {hist_b[LATENCY-2:0],
                    in_valid && (in_etype == 2'b00 || in_etype == 2'b11)};
      end
   end

   a_r5_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == hist_v[LATENCY-1]);

   a_r6_bad_slot: assert property (@(posedge clk) disable iff (!rst_n)
      out_bad_type == hist_b[LATENCY-1]);

   a_r6_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_bad_type |-> (out_valid && out_data == '0));

   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_data == '0 && !out_bad_type));

   a_r9_reset_clear: assert property (@(posedge clk)
      $past(!rst_n) |-> (!out_valid && !out_bad_type));
endmodule

bind simd_mul_unit vmul_sva #(.VEC_W(VEC_W), .LATENCY(LATENCY)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_etype     (in_etype),
   .out_valid    (out_valid),
   .out_bad_type (out_bad_type),
   .out_data     (out_data)
);

// File: tb/simd_mul_unit_bench.sv
module simd_mul_unit_bench;
   localparam int VW  = 256;
   localparam int MW  = VW / 16;
   localparam int LAT = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_etype = 2'b01;
   logic [MW-1:0] in_mask = '0;
   logic [VW-1:0] in_a = '0, in_b = '0;
   logic          out_valid, out_bad_type;
   logic [VW-1:0] out_data;

   int checks = 0;
   int errors = 0;

   logic          q_v[$];
   logic          q_b[$];
   logic [VW-1:0] q_d[$];
   string         q_r[$];

   always #5 clk = ~clk;

   simd_mul_unit #(.VEC_W(VW), .LATENCY(LAT)) u_simd_mul_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_etype(in_etype),
      .in_mask(in_mask), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_bad_type(out_bad_type), .out_data(out_data)
   );

   task automatic check1(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] model(logic v, logic [1:0] et, logic [MW-1:0] m,
                                           logic [VW-1:0] a, logic [VW-1:0] b);
      logic [VW-1:0] r = '0;
      if (!v) return r;
      if (et == 2'b01) begin
         for (int i = 0; i < VW/16; i++) begin
            logic [31:0] full = 32'(a[16*i +: 16]) * 32'(b[16*i +: 16]);
            if (m[i]) r[16*i +: 16] = full[15:0];
         end
      end else if (et == 2'b10) begin
         for (int k = 0; k < VW/32; k++) begin
            logic [63:0] full = 64'(a[32*k +: 32]) * 64'(b[32*k +: 32]);
            if (m[2*k]) r[32*k +: 32] = full[31:0];
         end
      end
      return r;
   endfunction

   // One clock: compare the slot due now, then drive the next request.
   task automatic step(logic v, logic [1:0] et, logic [MW-1:0] m,
                       logic [VW-1:0] a, logic [VW-1:0] b, string req);
      @(negedge clk);
      if (q_v.size() == LAT) begin
         logic          ev = q_v.pop_front();
         logic          eb = q_b.pop_front();
         logic [VW-1:0] ed = q_d.pop_front();
         string         er = q_r.pop_front();
         check1({"R5 valid ", er}, VW'(out_valid), VW'(ev));
         check1({"R6 bad ", er}, VW'(out_bad_type), VW'(eb));
         check1({"data ", er}, out_data, ed);
      end
      in_valid = v; in_etype = et; in_mask = m; in_a = a; in_b = b;
      q_v.push_back(v);
      q_b.push_back(v && (et == 2'b00 || et == 2'b11));
      q_d.push_back(model(v, et, m, a, b));
      q_r.push_back(req);
   endtask

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] r;
      for (int i = 0; i < VW/32; i++) r[32*i +: 32] = $urandom;
      return r;
   endfunction

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: outputs quiet during reset
      check1("R9 valid in reset", VW'(out_valid), '0);
      check1("R9 data in reset", out_data, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check1("R9 valid after reset", VW'(out_valid), '0);
      check1("R9 bad after reset", VW'(out_bad_type), '0);
      for (int i = 0; i < LAT; i++) begin
         q_v.push_back(1'b0); q_b.push_back(1'b0); q_d.push_back('0); q_r.push_back("R9 idle");
      end
      // R1 full mask, 16-bit lanes
      step(1, 2'b01, '1, rnd_vec(), rnd_vec(), "R1 h16 full mask");
      // R4 wrap: all ones squared
      step(1, 2'b01, '1, '1, '1, "R4 h16 wrap");
      step(1, 2'b10, '1, '1, '1, "R4 w32 wrap");
      // R2 32-bit lanes, odd mask bits only -> all zero
      step(1, 2'b10, {(MW/2){2'b10}}, rnd_vec(), rnd_vec(), "R2 w32 odd bits ignored");
      step(1, 2'b10, {(MW/2){2'b01}}, rnd_vec(), rnd_vec(), "R2 w32 even bits");
      // R3 partial masks, no merge of old data
      step(1, 2'b01, 16'hA5C3, rnd_vec(), rnd_vec(), "R3 h16 partial mask");
      step(1, 2'b01, '0, rnd_vec(), rnd_vec(), "R3 h16 empty mask");
      // R6 illegal types
      step(1, 2'b00, '1, rnd_vec(), rnd_vec(), "R6 b8 rejected");
      step(1, 2'b11, '1, rnd_vec(), rnd_vec(), "R6 reserved rejected");
      // R8 idle inputs have no effect
      for (int i = 0; i < 10; i++)
         step(0, 2'($urandom), MW'($urandom), rnd_vec(), rnd_vec(), "R8 idle garbage");
      // R7 full-rate mixed stream
      for (int i = 0; i < 300; i++)
         step(1, 2'($urandom), MW'($urandom), rnd_vec(), rnd_vec(), "R7 stream");
      for (int i = 0; i < 200; i++)
         step(($urandom % 3) != 0, 2'($urandom), MW'($urandom), rnd_vec(), rnd_vec(), "R7 gappy stream");
      // drain
      for (int i = 0; i < LAT + 1; i++) step(0, 2'b01, '0, '0, '0, "R8 drain");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule